// File: doc/BRIEF.md
# Five-Channel Down-Counting PWM Timer

This block is a bank of five independent down-counters driven from one clock. A simple register port configures it: one write strobe with address and data, and read data that follows the address within the same cycle. Each counter advances on its own tick enable. The tick comes from one of two shared 8-bit prescalers followed by a per-channel power-of-two divider. Software writes a reload value and a compare value into buffers. It copies them into the live counter with a manual-update bit, and then sets the start bit. When the counter passes zero it flags an interrupt and then reloads (periodic) or halts (one-shot).

Each channel drives one PWM pin whose level comes from comparing the live count against the active compare value. The polarity can be inverted per channel. The last channel has no compare buffer: its compare value is always zero, and its address slot holds that channel's count observation instead. Register accesses complete in one cycle with no back-pressure, so the port has no valid/ready pair. Every pin of the block is plain control or status.

Top module: `pwm_timer_bank`

## Requirements
- R1: After reset every register reads zero, every counter reads zero, every PWM pin is low and `irq` is low.
- R2: Registers read back what was written. The prescaler register at 0x00 keeps bits 15:0. The divider-select register at 0x04 keeps bits 19:0. A reload buffer (0x0C + 12*ch) or compare buffer (0x10 + 12*ch, channels 0 to 3 only) keeps all 32 bits. The interrupt register at 0x44 reads enables in bits 4:0 and pending flags in bits 9:5. Writing 0x40 changes nothing, and it reads channel 4's live count.
- R3: While a channel's manual-update bit is 1, its counter and active compare are copied from the buffers every clock. The copied count can be read in that channel's observation register (0x14 + 12*ch for ch 0 to 3, 0x40 for ch 4).
- R4: With start = 1 and manual update = 0, the counter falls by one on each of its ticks.
- R5: A channel ticks once every (P+1) * 2^S clocks. P is register 0x00 bits 7:0 for channels 0 and 1, and bits 15:8 for channels 2 to 4. S is the channel's 4-bit field at bits 4*ch+3:4*ch of 0x04, with values above 4 treated as 4.
- R6: With auto-reload = 1, a tick that finds the count at 0 reloads the count buffer, so loading N gives a period of N+1 ticks.
- R7: With auto-reload = 0, a tick that finds the count at 0 leaves it at 0 and halts the channel. No further pending flag is raised until the next manual update.
- R8: A channel's pending flag is set on the tick where its count at 0 expires. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. Enable bits take the written value.
- R9: `irq` is high exactly when some channel has both its enable and its pending flag set.
- R10: A PWM pin is high while count > active compare, and low otherwise. The channel's invert bit flips the level.
- R11: Register 0x08 holds four control bits per channel: bit 0 start, bit 1 manual update, bit 2 invert, bit 3 auto-reload. Channel 0 uses bits 3:0 and channel k > 0 uses bits 4(k+1)+3:4(k+1). Bits 7:4 are ignored and read zero.
- R12: With start = 0 and manual update = 0, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, takes effect at the rising edge |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pwm_out | output | 5 | One PWM level per channel |
| irq | output | 1 | OR of enabled pending flags |

## Verification
The hardest situation to reach is checking the tick period, because the prescaler and divider phases run freely from reset and cannot be read. The stimulus programs a non-trivial prescale and divide for channel 2 only. It then polls that channel's observation register every clock and measures the distance between successive changes, ignoring the first change, which has an unknown phase. One-shot halting is the other hard case. Its stimulus lets the counter expire, clears the flag, and then watches for many clocks to confirm that the flag never returns and the count stays at zero.

// File: rtl/pwm_timer_pkg.sv
`timescale 1ns/1ps
package pwm_timer_pkg;
  localparam int NCH    = 5;
  localparam int ADDR_W = 8;
  localparam int CTL_W  = 4;

  // control bit offsets inside one channel group
  localparam int CB_START  = 0;
  localparam int CB_MANUAL = 1;
  localparam int CB_INVERT = 2;
  localparam int CB_RELOAD = 3;

  localparam logic [ADDR_W-1:0] A_PSC  = 8'h00;
  localparam logic [ADDR_W-1:0] A_DSEL = 8'h04;
  localparam logic [ADDR_W-1:0] A_CTL  = 8'h08;
  localparam logic [ADDR_W-1:0] A_IRQ  = 8'h44;
  localparam logic [ADDR_W-1:0] A_OBS_LAST = 8'h40;

  function automatic logic [ADDR_W-1:0] rld_addr(int ch);
    return ADDR_W'(8'h0C + 12 * ch);
  endfunction

  function automatic logic [ADDR_W-1:0] cmp_addr(int ch);
    return ADDR_W'(8'h10 + 12 * ch);
  endfunction

  function automatic logic [ADDR_W-1:0] obs_addr(int ch);
    return (ch < NCH - 1) ? ADDR_W'(8'h14 + 12 * ch) : A_OBS_LAST;
  endfunction

  // channel 0 sits in the lowest nibble, later channels skip one nibble
  function automatic int ctl_base(int ch);
    return (ch == 0) ? 0 : CTL_W * (ch + 1);
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
`timescale 1ns/1ps
module pwm_prescaler #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PSC_W-1:0] psc,
  output logic             pre_tick
);
  logic [PSC_W-1:0] cnt_q;

  assign pre_tick = (cnt_q >= psc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (pre_tick) cnt_q <= '0;
    else               cnt_q <= cnt_q + PSC_W'(1);
  end
endmodule

// File: rtl/pwm_divider.sv
`timescale 1ns/1ps
module pwm_divider #(
  parameter int SEL_W   = 4,
  parameter int LOG_MAX = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pre_tick,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [LOG_MAX-1:0] div_q;
  logic [LOG_MAX-1:0] mask;
  logic [SEL_W-1:0]   sel_eff;

  always_comb begin
    sel_eff = (sel > SEL_W'(LOG_MAX)) ? SEL_W'(LOG_MAX) : sel;
    for (int i = 0; i < LOG_MAX; i++) mask[i] = (i < int'(sel_eff));
  end

  assign tick = pre_tick && ((div_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        div_q <= '0;
    else if (pre_tick) div_q <= div_q + LOG_MAX'(1);
  end
endmodule

// File: rtl/pwm_channel.sv
`timescale 1ns/1ps
module pwm_channel #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic             manual,
  input  logic             invert,
  input  logic             reload,
  input  logic [CNT_W-1:0] rld_buf,
  input  logic [CNT_W-1:0] cmp_buf,
  output logic [CNT_W-1:0] count,
  output logic             expire,
  output logic             pwm
);
  logic [CNT_W-1:0] cmp_act;
  logic             halted;

  assign expire = !manual && start && tick && !halted && (count == '0);
  assign pwm    = (count > cmp_act) ^ invert;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      cmp_act <= '0;
      halted  <= 1'b0;
    end else if (manual) begin
      count   <= rld_buf;
      cmp_act <= cmp_buf;
      halted  <= 1'b0;
    end else if (start && tick && !halted) begin
      if (count != '0) begin
        count <= count - CNT_W'(1);
      end else if (reload) begin
        count   <= rld_buf;
        cmp_act <= cmp_buf;
      end else begin
        halted <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_timer_bank.sv
`timescale 1ns/1ps
module pwm_timer_bank
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int PSC_W   = 8,
  parameter int SEL_W   = 4,
  parameter int LOG_MAX = 4,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NCH-1:0]    pwm_out,
  output logic              irq
);
  localparam int LO_GROUP = 2;  // channels below this use the low prescaler

  logic [PSC_W-1:0]                psc_lo, psc_hi;
  logic [NCH-1:0][SEL_W-1:0]       dsel;
  logic [NCH-1:0][CTL_W-1:0]       ctl_q;
  logic [NCH-1:0][CNT_W-1:0]       rld_buf;
  logic [NCH-2:0][CNT_W-1:0]       cmp_buf;
  logic [NCH-1:0]                  irq_en, irq_pend;

  logic [NCH-1:0][CNT_W-1:0]       cnt_q;
  logic [NCH-1:0]                  ch_tick, ch_exp;
  logic [NCH-1:0]                  ctl_start, ctl_manual, ctl_invert, ctl_reload;
  logic                            pre_lo, pre_hi;

  // register writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_lo  <= '0;
      psc_hi  <= '0;
      dsel    <= '0;
      ctl_q   <= '0;
      rld_buf <= '0;
      cmp_buf <= '0;
      irq_en  <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_PSC: begin
          psc_lo <= reg_wdata[PSC_W-1:0];
          psc_hi <= reg_wdata[2*PSC_W-1:PSC_W];
        end
        A_DSEL: dsel <= reg_wdata[NCH*SEL_W-1:0];
        A_CTL: begin
          for (int ch = 0; ch < NCH; ch++)
            ctl_q[ch] <= reg_wdata[ctl_base(ch) +: CTL_W];
        end
        A_IRQ: irq_en <= reg_wdata[NCH-1:0];
        default: begin
          for (int ch = 0; ch < NCH; ch++)
            if (reg_addr == rld_addr(ch)) rld_buf[ch] <= reg_wdata[CNT_W-1:0];
          for (int ch = 0; ch < NCH - 1; ch++)
            if (reg_addr == cmp_addr(ch)) cmp_buf[ch] <= reg_wdata[CNT_W-1:0];
        end
      endcase
    end
  end

  // pending flags: expiry wins over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_pend <= '0;
    end else begin
      for (int ch = 0; ch < NCH; ch++) begin
        if (ch_exp[ch])
          irq_pend[ch] <= 1'b1;
        else if (reg_wr && reg_addr == A_IRQ && reg_wdata[NCH + ch])
          irq_pend[ch] <= 1'b0;
      end
    end
  end

  assign irq = |(irq_en & irq_pend);

  // register reads
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_PSC:  reg_rdata[2*PSC_W-1:0] = {psc_hi, psc_lo};
      A_DSEL: reg_rdata[NCH*SEL_W-1:0] = dsel;
      A_CTL: begin
        for (int ch = 0; ch < NCH; ch++)
          reg_rdata[ctl_base(ch) +: CTL_W] = ctl_q[ch];
      end
      A_IRQ:  reg_rdata[2*NCH-1:0] = {irq_pend, irq_en};
      default: begin
        for (int ch = 0; ch < NCH; ch++) begin
          if (reg_addr == rld_addr(ch)) reg_rdata[CNT_W-1:0] = rld_buf[ch];
          if (reg_addr == obs_addr(ch)) reg_rdata[CNT_W-1:0] = cnt_q[ch];
        end
        for (int ch = 0; ch < NCH - 1; ch++)
          if (reg_addr == cmp_addr(ch)) reg_rdata[CNT_W-1:0] = cmp_buf[ch];
      end
    endcase
  end

  pwm_prescaler #(.PSC_W(PSC_W)) i_psc_lo (
    .clk(clk), .rst_n(rst_n), .psc(psc_lo), .pre_tick(pre_lo));
  pwm_prescaler #(.PSC_W(PSC_W)) i_psc_hi (
    .clk(clk), .rst_n(rst_n), .psc(psc_hi), .pre_tick(pre_hi));

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic             pre;
    logic [CNT_W-1:0] cmp_src;

    if (ch < LO_GROUP) begin : g_lo
      assign pre = pre_lo;
    end else begin : g_hi
      assign pre = pre_hi;
    end

    if (ch < NCH - 1) begin : g_cmp
      assign cmp_src = cmp_buf[ch];
    end else begin : g_nocmp
      assign cmp_src = '0;
    end

    assign ctl_start[ch]  = ctl_q[ch][CB_START];
    assign ctl_manual[ch] = ctl_q[ch][CB_MANUAL];
    assign ctl_invert[ch] = ctl_q[ch][CB_INVERT];
    assign ctl_reload[ch] = ctl_q[ch][CB_RELOAD];

    pwm_divider #(.SEL_W(SEL_W), .LOG_MAX(LOG_MAX)) i_div (
      .clk(clk), .rst_n(rst_n), .pre_tick(pre), .sel(dsel[ch]), .tick(ch_tick[ch]));

    pwm_channel #(.CNT_W(CNT_W)) i_chan (
      .clk(clk), .rst_n(rst_n), .tick(ch_tick[ch]),
      .start(ctl_start[ch]), .manual(ctl_manual[ch]),
      .invert(ctl_invert[ch]), .reload(ctl_reload[ch]),
      .rld_buf(rld_buf[ch]), .cmp_buf(cmp_src),
      .count(cnt_q[ch]), .expire(ch_exp[ch]), .pwm(pwm_out[ch]));
  end
endmodule

// File: rtl/pwm_timer_chk.sv
`timescale 1ns/1ps
module pwm_timer_chk #(
  parameter int NCH   = 5,
  parameter int CNT_W = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NCH-1:0]            tick,
  input logic [NCH-1:0]            start,
  input logic [NCH-1:0]            manual,
  input logic [NCH-1:0]            reload,
  input logic [NCH-1:0][CNT_W-1:0] cnt_q,
  input logic [NCH-1:0][CNT_W-1:0] rld_buf,
  input logic [NCH-1:0]            expire,
  input logic [NCH-1:0]            pend,
  input logic [NCH-1:0]            en,
  input logic                      irq
);
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      manual[ch] |=> cnt_q[ch] == $past(rld_buf[ch]));

    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!manual[ch] && start[ch] && tick[ch] && cnt_q[ch] != '0)
        |=> cnt_q[ch] == $past(cnt_q[ch]) - CNT_W'(1));

    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (expire[ch] && reload[ch]) |=> cnt_q[ch] == $past(rld_buf[ch]));

    p_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (expire[ch] && !reload[ch]) |=> cnt_q[ch] == '0);

    p_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      expire[ch] |=> pend[ch]);

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!manual[ch] && !start[ch]) |=> $stable(cnt_q[ch]));
  end

  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq);
endmodule

bind pwm_timer_bank pwm_timer_chk #(.NCH(pwm_timer_pkg::NCH), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .tick(ch_tick), .start(ctl_start), .manual(ctl_manual),
  .reload(ctl_reload), .cnt_q(cnt_q), .rld_buf(rld_buf), .expire(ch_exp),
  .pend(irq_pend), .en(irq_en), .irq(irq));

// File: tb/test_pwm_timer_bank.sv
`timescale 1ns/1ps
module test_pwm_timer_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [4:0]  pwm_out;
  logic        irq;
  int          total = 0;
  int          bad = 0;

  always #10 clk = ~clk;

  pwm_timer_bank i_pwm_timer_bank (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 pwm", {27'd0, pwm_out}, 32'd0);
    rd(8'h08, d); check("R1 ctl", d, 32'd0);
    rd(8'h14, d); check("R1 count0", d, 32'd0);
    rd(8'h44, d); check("R1 irqreg", d, 32'd0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); check("R2 prescale", d, 32'h0000_FFFF);
    wr(8'h00, 32'h0);
    wr(8'h04, 32'hFFF4_3210); rd(8'h04, d); check("R2 dsel", d, 32'h0004_3210);
    wr(8'h04, 32'h0);
    wr(8'hFF & 8'h08, 32'hFFFF_FFFF); rd(8'h08, d); check("R11 ctl layout", d, 32'h00FF_FF0F);
    wr(8'h08, 32'h0);
    wr(8'h30, 32'hDEAD_BEEF); rd(8'h30, d); check("R2 reload ch3", d, 32'hDEAD_BEEF);
    wr(8'h28, 32'h0000_0055); rd(8'h28, d); check("R2 compare ch2", d, 32'h55);
    wr(8'h40, 32'h0000_1234); rd(8'h40, d); check("R2 0x40 write ignored", d, 32'h0);
    wr(8'h44, 32'h0000_001F); rd(8'h44, d); check("R2 enables", d, 32'h1F);
    wr(8'h44, 32'h0);
  endtask

  task automatic t_periodic();
    logic [31:0] d;
    wr(8'h0C, 32'd5);
    wr(8'h08, 32'h2);
    wr(8'h08, 32'h9);
    rd(8'h14, d); check("R3 manual load", d, 32'd5);
    nclk(3); rd(8'h14, d); check("R4 down count", d, 32'd2);
    nclk(2); rd(8'h14, d); check("R4 reach zero", d, 32'd0);
    rd(8'h44, d); check("R8 no flag before expiry", d, 32'h0);
    nclk(1); rd(8'h14, d); check("R6 reload", d, 32'd5);
    rd(8'h44, d); check("R8 flag on expiry", d, 32'h20);
    nclk(6); rd(8'h14, d); check("R6 period N+1", d, 32'd5);
    wr(8'h44, 32'h20); rd(8'h44, d); check("R8 w1c", d, 32'h0);
    wr(8'h08, 32'h8);
    rd(8'h14, d);
    begin
      logic [31:0] d2;
      nclk(4); rd(8'h14, d2); check("R12 hold", d2, d);
    end
  endtask

  task automatic t_oneshot();
    logic [31:0] d;
    wr(8'h44, 32'h20);
    wr(8'h0C, 32'd3);
    wr(8'h08, 32'h2);
    wr(8'h08, 32'h1);
    nclk(3); rd(8'h14, d); check("R7 count zero", d, 32'd0);
    nclk(1); rd(8'h44, d); check("R7 flag once", d, 32'h20);
    rd(8'h14, d); check("R7 stays zero", d, 32'd0);
    wr(8'h44, 32'h20);
    nclk(8);
    rd(8'h44, d); check("R7 no repeat flag", d, 32'h0);
    rd(8'h14, d); check("R7 halted", d, 32'd0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(8'h0C, 32'd0);
    wr(8'h08, 32'h2);
    wr(8'h08, 32'h1);
    nclk(2);
    check("R9 irq masked", {31'd0, irq}, 32'd0);
    wr(8'h44, 32'h01);
    check("R9 irq raised", {31'd0, irq}, 32'd1);
    rd(8'h44, d); check("R8 enable and flag", d, 32'h21);
    wr(8'h44, 32'h00);
    rd(8'h44, d); check("R8 write 0 keeps flag", d, 32'h20);
    check("R9 irq disabled", {31'd0, irq}, 32'd0);
    wr(8'h44, 32'h02);
    check("R9 other enable", {31'd0, irq}, 32'd0);
    wr(8'h44, 32'h21);
    check("R9 cleared", {31'd0, irq}, 32'd0);
    rd(8'h44, d); check("R8 clear with enable", d, 32'h01);
    wr(8'h44, 32'h0);
    wr(8'h08, 32'h0);
  endtask

  task automatic t_pwm();
    logic [31:0] d;
    wr(8'h18, 32'd9);
    wr(8'h1C, 32'd4);
    wr(8'h08, 32'h200);
    wr(8'h08, 32'h900);
    rd(8'h20, d); check("R3 obs ch1", d, 32'd9);
    check("R10 high above compare", {31'd0, pwm_out[1]}, 32'd1);
    nclk(4); check("R10 high at 5", {31'd0, pwm_out[1]}, 32'd1);
    nclk(1); check("R10 low at compare", {31'd0, pwm_out[1]}, 32'd0);
    nclk(5); check("R10 high after reload", {31'd0, pwm_out[1]}, 32'd1);
    wr(8'h08, 32'h600);
    check("R10 inverted", {31'd0, pwm_out[1]}, 32'd0);
    wr(8'h08, 32'h0);
    wr(8'h44, 32'h3E0);
  endtask

  task automatic t_prescale();
    logic [31:0] d, prev;
    int last_t, nint;
    wr(8'h00, 32'h0000_0200);
    wr(8'h04, 32'h0000_0100);
    wr(8'h24, 32'd1000);
    wr(8'h08, 32'h2000);
    wr(8'h08, 32'h9000);
    rd(8'h2C, prev);
    last_t = -1;
    nint = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      rd(8'h2C, d);
      if (d != prev) begin
        if (last_t >= 0 && nint < 4) begin
          check("R5 tick spacing", i - last_t, 32'd6);
          nint++;
        end
        last_t = i;
        prev = d;
      end
    end
    check("R5 intervals seen", nint, 32'd4);
    wr(8'h08, 32'h0);
  endtask

  initial begin
    nclk(3);
    rst_n = 1'b1;
    nclk(1);
    t_reset();
    t_regs();
    t_periodic();
    t_oneshot();
    t_irq();
    t_pwm();
    t_prescale();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule